// File: doc/BRIEF.md
# Flash Cache-Program Status Engine

This block models the control and status logic of a single flash die while it runs a cache program sequence. Each program unit is a 4 KB page, staged by the host in two 2 KB staging buffers. The host then writes either a cache-program command or a plain program command. The engine moves the staged page into the page buffer one sector at a time, eight sectors per page. When that copy completes, the engine starts an array program. The array program time is modelled by a cycle counter whose length is a parameter.

A cache command frees the staging buffers as soon as the copy has finished, so the host can load the next page while the previous page is still being programmed into the array. A plain program command ends the sequence. For that command the ready bit stays low until its own array program has finished.

The status word reports the following:
- the ready/interrupt bit;
- an ongoing bit that covers the whole sequence;
- a general error bit for refused commands;
- two pass/fail bits, one for the previous array program and one for the current array program.

A command is refused in any of these cases: the target block is locked, the target is in the OTP block or the first-block OTP area, or the page lies in a different partition type than the page that started the sequence.

Top module: `fcp_engine`

## Requirements
- R1: After reset, int_o = 1 and the status word reads 0x10: ready bit set, and the ongoing, general error, previous and current bits all clear.
- R2: The command codes are cache program = 0x007F and plain program = 0x0080. A command written with cmd_we while int_o = 1, and not refused, is accepted. In the cycle after acceptance int_o = 0 and ongoing = 1.
- R3: The copy into the page buffer takes SECTORS*SECT_CYC cycles, which is 32 with the defaults. When the array is idle, a cache command's ready bit returns to 1 exactly that many clock edges after the acceptance edge. The array program starts on that same edge.
- R4: For a plain program command, int_o stays 0 until that page's array program has finished. That is copy time plus PROG_CYC edges, 72 with the defaults, when the array is idle at acceptance. At that point int_o returns to 1.
- R5: The ongoing bit stays 1 across all cache pages and any waits between them. It clears on the same edge on which the final plain-program page finishes its array program.
- R6: At the end of each array program, the previous-error bit takes the old current-error bit. The current-error bit takes the fail result: force_fail sampled on the edge that starts that array program (1 = fail). The first accepted command of a sequence clears both bits.
- R7: A command whose target is locked (blk_locked), in the OTP block (cmd_otp) or in the first-block OTP area (cmd_otp_first) is refused. A refused command sets the general error bit, leaves int_o = 1 and leaves ongoing unchanged. The next accepted command clears the general error bit.
- R8: A command arriving while ongoing = 1 whose cmd_mlc differs from the partition type captured at the start of the sequence is refused in the same way as in R7.
- R9: If a command is accepted while an array program is still running, the copy waits with int_o = 0. The copy starts on the edge after the array program ends.
- R10: A command written while int_o = 0, or with any other command code, has no effect on the status word or on the timing.
- Status word stat_o: bit 0 = ongoing, bit 1 = general error, bit 2 = previous error, bit 3 = current error, bit 4 = ready/interrupt, bits 7..5 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 16 | Command code |
| cmd_mlc | input | 1 | Target page partition type (1 = MLC, 0 = SLC) |
| cmd_otp | input | 1 | Target lies in the OTP block |
| cmd_otp_first | input | 1 | Target lies in the first-block OTP area |
| blk_locked | input | 1 | Lock state of the target block |
| force_fail | input | 1 | Test input: the next array program reports fail |
| stat_o | output | 8 | Status word |
| int_o | output | 1 | Ready/interrupt bit |

## Verification
Two events can land on the same clock edge. One is the end of the previous page's array program, which updates the previous and current error bits. The other is the acceptance of the next cache command, which must then wait one more edge before its copy starts. The bench provokes this by timing a cache command so that it is accepted on exactly the edge the earlier page's program counter expires. It then judges the result on two points: the error bits take the finished page's result, and the new page's ready bit returns 105 edges after the sequence start instead of earlier.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int OPW = 16;
  localparam logic [OPW-1:0] OP_CACHE = 16'h007F;
  localparam logic [OPW-1:0] OP_PROG  = 16'h0080;

  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_WAIT = 2'd1,
    CP_COPY = 2'd2
  } cp_state_e;

  localparam int ST_ONGO = 0;
  localparam int ST_GERR = 1;
  localparam int ST_PREV = 2;
  localparam int ST_CUR  = 3;
  localparam int ST_RDY  = 4;
endpackage

// File: rtl/fcp_copy_seq.sv
module fcp_copy_seq
  import fcp_pkg::*;
#(
  parameter int SECTORS  = 8,
  parameter int SECT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic active,
  output logic done
);
  localparam int SW = (SECTORS  > 1) ? $clog2(SECTORS)  : 1;
  localparam int BW = (SECT_CYC > 1) ? $clog2(SECT_CYC) : 1;

  cp_state_e         state_q, state_d;
  logic [SW-1:0]     sec_q, sec_d;
  logic [BW-1:0]     beat_q, beat_d;
  logic [SECTORS-1:0] mask_q, mask_d;
  logic              beat_last;
  logic              launch;

  assign beat_last = (beat_q == BW'(SECT_CYC - 1));
  assign launch    = (state_d == CP_COPY) && (state_q != CP_COPY);

  always_comb begin
    state_d = state_q;
    sec_d   = sec_q;
    beat_d  = beat_q;
    done    = 1'b0;
    case (state_q)
      CP_IDLE: begin
        if (start) begin
          state_d = hold ? CP_WAIT : CP_COPY;
          sec_d   = '0;
          beat_d  = '0;
        end
      end
      CP_WAIT: begin
        if (!hold) begin
          state_d = CP_COPY;
          sec_d   = '0;
          beat_d  = '0;
        end
      end
      CP_COPY: begin
        if (beat_last) begin
          beat_d = '0;
          if (sec_q == SW'(SECTORS - 1)) begin
            done    = 1'b1;
            state_d = CP_IDLE;
          end else begin
            sec_d = sec_q + 1'b1;
          end
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      default: state_d = CP_IDLE;
    endcase
  end

  for (genvar g = 0; g < SECTORS; g++) begin : g_sec
    assign mask_d[g] = launch ? 1'b0 :
                       ((state_q == CP_COPY) && beat_last && (sec_q == SW'(g))) ? 1'b1 :
                       mask_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CP_IDLE;
      sec_q   <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
      beat_q  <= beat_d;
      mask_q  <= mask_d;
    end
  end

  assign active = (state_q != CP_IDLE);

  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CP_COPY) |-> (int'(sec_q) < SECTORS)); // R3
  AST_ALL_SECTORS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(mask_q) == SECTORS - 1)); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CP_COPY) |-> !hold); // R9
endmodule

// File: rtl/fcp_array_timer.sv
module fcp_array_timer #(
  parameter int PROG_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fail_in,
  output logic busy,
  output logic done,
  output logic fail_q
);
  localparam int CW = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d, fail_d;

  assign done = busy && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    fail_d = fail_q;
    if (start) begin
      cnt_d  = CW'(PROG_CYC - 1);
      busy_d = 1'b1;
      fail_d = fail_in;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy   <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy   <= busy_d;
      fail_q <= fail_d;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3
endmodule

// File: rtl/fcp_engine.sv
module fcp_engine
  import fcp_pkg::*;
#(
  parameter int SECTORS  = 8,
  parameter int SECT_CYC = 4,
  parameter int PROG_CYC = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic [OPW-1:0] cmd_op,
  input  logic           cmd_mlc,
  input  logic           cmd_otp,
  input  logic           cmd_otp_first,
  input  logic           blk_locked,
  input  logic           force_fail,
  output logic [7:0]     stat_o,
  output logic           int_o
);
  logic int_q, int_d;
  logic ongo_q, ongo_d;
  logic gerr_q, gerr_d;
  logic prev_q, prev_d;
  logic cur_q, cur_d;
  logic mlc_q, mlc_d;
  logic last_q, last_d;
  logic fin_q, fin_d;

  logic known, offered, refuse, take;
  logic copy_active, copy_done;
  logic arr_busy, arr_done, arr_fail;

  assign known   = (cmd_op == OP_CACHE) || (cmd_op == OP_PROG);
  assign offered = cmd_we && int_q && known;
  assign refuse  = offered && (blk_locked || cmd_otp || cmd_otp_first ||
                               (ongo_q && (cmd_mlc != mlc_q)));
  assign take    = offered && !refuse;

  fcp_copy_seq #(.SECTORS(SECTORS), .SECT_CYC(SECT_CYC)) u_copy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (take),
    .hold   (arr_busy),
    .active (copy_active),
    .done   (copy_done)
  );

  fcp_array_timer #(.PROG_CYC(PROG_CYC)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (copy_done),
    .fail_in (force_fail),
    .busy    (arr_busy),
    .done    (arr_done),
    .fail_q  (arr_fail)
  );

  always_comb begin
    int_d  = int_q;
    ongo_d = ongo_q;
    gerr_d = gerr_q;
    prev_d = prev_q;
    cur_d  = cur_q;
    mlc_d  = mlc_q;
    last_d = last_q;
    fin_d  = fin_q;

    if (refuse) gerr_d = 1'b1;

    if (take) begin
      int_d  = 1'b0;
      ongo_d = 1'b1;
      gerr_d = 1'b0;
      last_d = (cmd_op == OP_PROG);
      if (!ongo_q) begin
        mlc_d  = cmd_mlc;
        prev_d = 1'b0;
        cur_d  = 1'b0;
      end
    end

    if (copy_done) begin
      if (last_q) fin_d = 1'b1;
      else        int_d = 1'b1;
    end

    if (arr_done) begin
      prev_d = cur_q;
      cur_d  = arr_fail;
      if (fin_q) begin
        fin_d  = 1'b0;
        int_d  = 1'b1;
        ongo_d = 1'b0;
        last_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= 1'b1;
      ongo_q <= 1'b0;
      gerr_q <= 1'b0;
      prev_q <= 1'b0;
      cur_q  <= 1'b0;
      mlc_q  <= 1'b0;
      last_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      int_q  <= int_d;
      ongo_q <= ongo_d;
      gerr_q <= gerr_d;
      prev_q <= prev_d;
      cur_q  <= cur_d;
      mlc_q  <= mlc_d;
      last_q <= last_d;
      fin_q  <= fin_d;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_ONGO] = ongo_q;
    stat_o[ST_GERR] = gerr_q;
    stat_o[ST_PREV] = prev_q;
    stat_o[ST_CUR]  = cur_q;
    stat_o[ST_RDY]  = int_q;
  end
  assign int_o = int_q;

  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!int_q && ongo_q)); // R2
  AST_REFUSE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (int_q && gerr_q)); // R7
  AST_REFUSE_ONGO: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (ongo_q == $past(ongo_q))); // R8
  AST_CACHE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_done && !last_q) |=> int_q); // R3
  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && arr_busy) |-> !int_q); // R4
  AST_ONGO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ongo_q) |-> $past(arr_done)); // R5
  AST_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    copy_active |-> !int_q); // R9
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !int_q && !copy_done && !arr_done) |=> $stable(stat_o)); // R10
endmodule

// File: tb/sim_fcp_engine.sv
module sim_fcp_engine;
  localparam int SECTORS  = 8;
  localparam int SECT_CYC = 4;
  localparam int PROG_CYC = 40;
  localparam int COPY_LEN = SECTORS * SECT_CYC;
  localparam logic [15:0] C_CACHE = 16'h007F;
  localparam logic [15:0] C_PROG  = 16'h0080;

  // fields: [23:8] op, [7] mlc, [6] otp, [5] otp_first, [4] lock, [3] fail,
  //         [2] expect accepted, [1] expect general error, [0] spare
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {C_PROG,  8'b0000_0100},
    {C_PROG,  8'b0000_1100},
    {C_PROG,  8'b0001_0010},
    {C_CACHE, 8'b0100_0010},
    {C_PROG,  8'b0010_0010},
    {16'h0011,8'b0000_0010},
    {C_PROG,  8'b1000_0100},
    {C_CACHE, 8'b0001_0010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_op = '0;
  logic        cmd_mlc = 1'b0, cmd_otp = 1'b0, cmd_otp_first = 1'b0;
  logic        blk_locked = 1'b0, force_fail = 1'b0;
  logic [7:0]  stat_o;
  logic        int_o;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int t_acc = 0;
  int t0 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fcp_engine #(.SECTORS(SECTORS), .SECT_CYC(SECT_CYC), .PROG_CYC(PROG_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op),
    .cmd_mlc(cmd_mlc), .cmd_otp(cmd_otp), .cmd_otp_first(cmd_otp_first),
    .blk_locked(blk_locked), .force_fail(force_fail),
    .stat_o(stat_o), .int_o(int_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] op, input logic mlc, input logic otp,
                       input logic otp1, input logic lock, input logic fail);
    @(negedge clk);
    cmd_we = 1'b1; cmd_op = op; cmd_mlc = mlc; cmd_otp = otp;
    cmd_otp_first = otp1; blk_locked = lock; force_fail = fail;
    @(posedge clk); #1;
    cmd_we = 1'b0;
    t_acc = cyc;
  endtask

  task automatic wait_rdy();
    while (!int_o) begin @(posedge clk); #1; end
  endtask

  task automatic wait_until(input int tgt);
    while (cyc < tgt - 1) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(stat_o == 8'h10, "R1 reset status", stat_o, 8'h10);
    chk(int_o == 1'b1, "R1 reset int", int_o, 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // single-page vectors from idle
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      issue(v[23:8], v[7], v[6], v[5], v[4], v[3]);
      if (v[2]) begin
        chk(int_o == 0 && stat_o[0] == 1, "R2 accepted busy", stat_o, 8'h01);
        t0 = t_acc;
        wait_rdy();
        chk(cyc - t0 == COPY_LEN + PROG_CYC, "R4 plain release time", cyc - t0, COPY_LEN + PROG_CYC);
        chk(stat_o[0] == 0, "R5 ongoing clear", stat_o[0], 0);
        chk(stat_o[3] == v[3], "R6 current error", stat_o[3], v[3]);
        chk(stat_o[2] == 0, "R6 previous cleared", stat_o[2], 0);
        chk(stat_o[1] == 0, "R7 general error cleared", stat_o[1], 0);
      end else begin
        chk(int_o == 1 && stat_o[0] == 0, "R7/R10 ready kept", stat_o, 8'h10);
        chk(stat_o[1] == v[1], "R7/R10 general error", stat_o[1], v[1]);
      end
      repeat (2) @(posedge clk); #1;
    end

    // cache sequence: A(fail) B(pass) C(plain, fail)
    issue(C_CACHE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    t0 = t_acc;
    chk(int_o == 0, "R2 cache busy", int_o, 0);
    repeat (4) @(posedge clk);
    issue(C_PROG, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(int_o == 0 && stat_o[1] == 0, "R10 ignored while busy", stat_o, 8'h01);
    force_fail = 1'b1;
    wait_rdy();
    chk(cyc - t0 == COPY_LEN, "R3 cache release time", cyc - t0, COPY_LEN);
    chk(stat_o[0] == 1, "R5 ongoing after cache copy", stat_o[0], 1);
    issue(C_CACHE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(stat_o[1] == 1 && int_o == 1, "R8 partition mismatch refused", stat_o, 8'h13);
    issue(C_CACHE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(int_o == 0 && stat_o[1] == 0, "R9 accepted while array busy", stat_o, 8'h01);
    while (!stat_o[3]) begin @(posedge clk); #1; end
    chk(cyc - t0 == COPY_LEN + PROG_CYC, "R6 first result time", cyc - t0, COPY_LEN + PROG_CYC);
    chk(stat_o[2] == 0, "R6 previous after A", stat_o[2], 0);
    wait_rdy();
    chk(cyc - t0 == 2 * COPY_LEN + PROG_CYC + 1, "R9 stalled copy release", cyc - t0, 2 * COPY_LEN + PROG_CYC + 1);
    issue(C_PROG, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    while (!stat_o[2]) begin @(posedge clk); #1; end
    chk(cyc - t0 == 2 * COPY_LEN + 2 * PROG_CYC + 1, "R6 second result time", cyc - t0, 2 * COPY_LEN + 2 * PROG_CYC + 1);
    chk(stat_o[3] == 0 && stat_o[0] == 1 && int_o == 0, "R4/R5 final still running", stat_o, 8'h05);
    wait_rdy();
    chk(cyc - t0 == 3 * COPY_LEN + 3 * PROG_CYC + 2, "R4 final release time", cyc - t0, 3 * COPY_LEN + 3 * PROG_CYC + 2);
    chk(stat_o == 8'h18, "R5/R6 final status", stat_o, 8'h18);

    // acceptance on the same edge the array program finishes
    repeat (3) @(posedge clk); #1;
    issue(C_CACHE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    t0 = t_acc;
    wait_rdy();
    chk(cyc - t0 == COPY_LEN, "R3 second sequence release", cyc - t0, COPY_LEN);
    chk(stat_o[3] == 0 && stat_o[2] == 0, "R6 cleared at sequence start", stat_o, 8'h11);
    wait_until(t0 + COPY_LEN + PROG_CYC);
    issue(C_CACHE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(t_acc - t0 == COPY_LEN + PROG_CYC, "R9 coincident accept edge", t_acc - t0, COPY_LEN + PROG_CYC);
    chk(stat_o[3] == 1 && int_o == 0, "R6 result with coincident accept", stat_o, 8'h09);
    wait_rdy();
    chk(cyc - t0 == 2 * COPY_LEN + PROG_CYC + 1, "R9 coincident release", cyc - t0, 2 * COPY_LEN + PROG_CYC + 1);
    issue(C_PROG, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_rdy();
    chk(stat_o == 8'h10, "R5/R6 end of second sequence", stat_o, 8'h10);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule